// File: doc/BRIEF.md
# Serial Flash Control Sequencer

This block sits behind the register decoder of a synchronous serial port that runs in SPI mode. It owns the second control word. Writing that word can launch one-cycle clear strobes toward the transmit and receive FIFOs and a full port reset. In serial flash mode the word also chooses which chip-select line is in use and at what level it sits. A write to the data offset splits the written word into bytes and pushes them, low byte first, into an external transmit FIFO. When the port is enabled in SPI format with transmit on, every control or data write is followed by a drain that sends every byte held in the FIFO to an external bit shifter.

The FIFO push interface and the shifter interface are valid/ready streams. On the shifter side, `sh_valid` stays high for as long as the FIFO holds a byte during a drain, and a byte counts as sent on any cycle where `sh_valid` and `sh_ready` are both high. The FIFO push side differs on purpose, because a full FIFO ends a data write early. If `push_ready` is low while `push_valid` is high, the bytes still pending for that write are dropped and `push_valid` falls on the next cycle. The FIFOs and the shifter are outside the block. The FIFO must present `fifo_empty` and `fifo_rdata` from registered state.

Top module: `spi_flash_ctl_seq`

## Requirements
- R1: After reset the stored control word reads 0, `busy`, `tx_clr`, `rx_clr`, `push_valid` and `sh_valid` are low, and with `flash_mode` low all `cs_lines` are 1.
- R2: `rd_data` is combinational from `rd_addr`: 0x08 gives the stored control word, 0x60 gives 0x00011901, 0x64 gives 0x660F0F1F, and any other offset gives 0. An address with bits [1:0] not zero also gives 0.
- R3: A write whose address has bits [1:0] not zero changes nothing: not the control word, not the FIFO.
- R4: A write to 0x08 stores the data with bits 6, 3 and 2 forced to 0. Bit 3 makes `tx_clr` high for exactly the cycle after the write, and bit 2 does the same for `rx_clr`.
- R5: Bit 6 (port reset) of a 0x08 write pulses both `tx_clr` and `rx_clr`, drops `busy` at once and aborts any push or drain in progress. With `flash_mode` high it also sets bit 9 of the stored word.
- R6: With `flash_mode` high, line `cs_lines[k]` is 0 only when k equals stored bits [11:10] and stored bit 9 is 0. Every other line is 1. With `flash_mode` low all lines are 1.
- R7: A write to 0x18 while stored bit 0 (enable) is 1 pushes `sample_bytes` bytes (1 to 4) of the data, bits [7:0] first, one per cycle starting the cycle after the write. The first cycle with `push_ready` low ends the write, and its remaining bytes are lost. With bit 0 at 0 nothing is pushed.
- R8: A drain runs when `fmt_sel` is 1 and bits 0 and 8 are set in the control word. The word is taken from the write data for a 0x08 write, and from the stored word after a 0x18 push. The drain sends every FIFO byte in order to the shifter. It does not run for any other `fmt_sel`.
- R9: A drain that finds the FIFO empty on its first cycle raises `underrun` for one cycle.
- R10: `busy` goes high the cycle after a byte is handed to the shifter. It stays high while any handed byte lacks its `sh_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | ADDR_W | write byte offset |
| wr_data | input | 32 | write data |
| rd_addr | input | ADDR_W | read byte offset |
| rd_data | output | 32 | read data |
| fmt_sel | input | 3 | frame format from control word 0 (1 = SPI) |
| flash_mode | input | 1 | serial flash mode from control word 0 |
| sample_bytes | input | 3 | bytes per sample, 1 to 4 |
| tx_clr | output | 1 | transmit FIFO clear strobe |
| rx_clr | output | 1 | receive FIFO clear strobe |
| cs_lines | output | NCS | chip-select levels |
| push_valid | output | 1 | FIFO push valid |
| push_ready | input | 1 | FIFO not full |
| push_data | output | 8 | byte pushed to the FIFO |
| fifo_empty | input | 1 | transmit FIFO empty |
| fifo_rdata | input | 8 | FIFO head byte |
| fifo_pop | output | 1 | pop the FIFO head |
| sh_valid | output | 1 | byte offered to the shifter |
| sh_ready | input | 1 | shifter accepts a byte |
| sh_data | output | 8 | byte to the shifter |
| sh_done | input | 1 | shifter finished one byte |
| underrun | output | 1 | drain started on an empty FIFO |
| busy | output | 1 | shifter bytes outstanding |

## Verification
The clear strobes, the stored word and the chip selects change at the write edge, so the bench samples them at the falling edge that ends the write task. Read data is combinational and is sampled a short time after `rd_addr` changes. The first push lands one edge after the write. A drain starts two edges after the last push, or two edges after a control write. This gap lets a clear land in the FIFO first. For these multi-cycle results, the bench waits a bounded number of cycles or polls `busy`, and only then checks FIFO depth and the underrun count. The scoreboard compares each shifter byte on the falling edge before the rising edge that accepts it.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;
  localparam logic [7:0] OFF_CTL2 = 8'h08;
  localparam logic [7:0] OFF_DATA = 8'h18;
  localparam logic [7:0] OFF_REV  = 8'h60;
  localparam logic [7:0] OFF_FEAT = 8'h64;
  localparam logic [31:0] REV_VALUE  = 32'h0001_1901;
  localparam logic [31:0] FEAT_VALUE = 32'h660F_0F1F;
  // control word bit positions
  localparam int B_EN    = 0;
  localparam int B_RXCLR = 2;
  localparam int B_TXCLR = 3;
  localparam int B_PRST  = 6;
  localparam int B_TXEN  = 8;
  localparam int B_LVL   = 9;
  localparam int B_SEL   = 10;
  localparam logic [2:0] FMT_SPI = 3'd1;
  typedef enum logic [1:0] {SQ_IDLE, SQ_PUSH, SQ_SETTLE, SQ_DRAIN} sq_state_e;
endpackage

// File: rtl/sfseq_ctl_reg.sv
module sfseq_ctl_reg
  import sfseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              flash_mode,
  output logic [31:0]       rd_data,
  output logic [31:0]       ctl_q,
  output logic              ctl_wr,
  output logic              prst_now,
  output logic              tx_clr,
  output logic              rx_clr,
  output logic [NCS-1:0]    cs_lines
);
  localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1;

  logic [31:0]      ctl_nxt;
  logic [SEL_W-1:0] sel;

  assign ctl_wr   = wr_en && (wr_addr[1:0] == 2'b00) && (wr_addr == ADDR_W'(OFF_CTL2));
  assign prst_now = ctl_wr && wr_data[B_PRST];

  always_comb begin
    ctl_nxt = wr_data;
    ctl_nxt[B_PRST]  = 1'b0;
    ctl_nxt[B_TXCLR] = 1'b0;
    ctl_nxt[B_RXCLR] = 1'b0;
    if (prst_now && flash_mode) ctl_nxt[B_LVL] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      tx_clr <= 1'b0;
      rx_clr <= 1'b0;
    end else begin
      tx_clr <= ctl_wr && (wr_data[B_TXCLR] || wr_data[B_PRST]);
      rx_clr <= ctl_wr && (wr_data[B_RXCLR] || wr_data[B_PRST]);
      if (ctl_wr) ctl_q <= ctl_nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[1:0] == 2'b00) begin
      if (rd_addr == ADDR_W'(OFF_CTL2))      rd_data = ctl_q;
      else if (rd_addr == ADDR_W'(OFF_REV))  rd_data = REV_VALUE;
      else if (rd_addr == ADDR_W'(OFF_FEAT)) rd_data = FEAT_VALUE;
    end
  end

  assign sel = ctl_q[B_SEL +: SEL_W];

  for (genvar gi = 0; gi < NCS; gi++) begin : g_cs
    assign cs_lines[gi] = !(flash_mode && (sel == SEL_W'(gi)) && !ctl_q[B_LVL]);
  end

  // R4: a clear bit in the written word yields the strobe one edge later
  a_r4_txclr_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[B_TXCLR]) |=> tx_clr);
  // R5: port reset in flash mode leaves the level bit set
  a_r5_level_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (prst_now && flash_mode) |=> (ctl_q[B_LVL] && !ctl_q[B_PRST]));
  // R6: at most one chip select is ever low
  a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_lines) <= 1);
endmodule

// File: rtl/sfseq_tx_seq.sv
module sfseq_tx_seq
  import sfseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_wr,
  input  logic        ctl_wr,
  input  logic        prst_now,
  input  logic [31:0] wr_data,
  input  logic [31:0] ctl_q,
  input  logic [2:0]  fmt_sel,
  input  logic [2:0]  sample_bytes,
  output logic        push_valid,
  input  logic        push_ready,
  output logic [7:0]  push_data,
  input  logic        fifo_empty,
  input  logic [7:0]  fifo_rdata,
  output logic        fifo_pop,
  output logic        sh_valid,
  input  logic        sh_ready,
  output logic [7:0]  sh_data,
  output logic        underrun
);
  sq_state_e   state;
  logic [31:0] word_q;
  logic [1:0]  idx_q, last_q, last_idx;
  logic        first_q;
  logic        spi_fmt, drain_wr_cfg, drain_st_cfg;

  assign spi_fmt      = (fmt_sel == FMT_SPI);
  assign drain_wr_cfg = spi_fmt && wr_data[B_EN] && wr_data[B_TXEN];
  assign drain_st_cfg = spi_fmt && ctl_q[B_EN] && ctl_q[B_TXEN];

  always_comb begin
    if (sample_bytes == 3'd0)      last_idx = 2'd0;
    else if (sample_bytes >= 3'd4) last_idx = 2'd3;
    else                           last_idx = 2'(sample_bytes - 3'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      word_q   <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      first_q  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (ctl_wr && (prst_now || state == SQ_IDLE)) begin
        state <= drain_wr_cfg ? SQ_SETTLE : SQ_IDLE;
      end else begin
        case (state)
          SQ_IDLE: if (data_wr && ctl_q[B_EN]) begin
            word_q <= wr_data;
            idx_q  <= '0;
            last_q <= last_idx;
            state  <= SQ_PUSH;
          end
          SQ_PUSH: begin
            if (!push_ready || idx_q == last_q) state <= drain_st_cfg ? SQ_SETTLE : SQ_IDLE;
            else idx_q <= idx_q + 2'd1;
          end
          SQ_SETTLE: begin
            first_q <= 1'b1;
            state   <= SQ_DRAIN;
          end
          SQ_DRAIN: begin
            first_q <= 1'b0;
            if (fifo_empty) begin
              underrun <= first_q;
              state    <= SQ_IDLE;
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end

  assign push_valid = (state == SQ_PUSH);
  assign push_data  = word_q[{idx_q, 3'b000} +: 8];
  assign sh_valid   = (state == SQ_DRAIN) && !fifo_empty;
  assign sh_data    = fifo_rdata;
  assign fifo_pop   = sh_valid && sh_ready;

  // R7: a refused push ends the data write
  a_r7_stop_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> !push_valid);
  // R9: an underrun report lasts a single cycle
  a_r9_underrun_single: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);
  // R8: pushing and draining never overlap
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> !fifo_pop);
endmodule

// File: rtl/sfseq_busy.sv
module sfseq_busy #(
  parameter int OUT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic done,
  input  logic clear,
  output logic busy
);
  logic [OUT_W-1:0] cnt_q;
  logic             inc, dec;

  assign inc = launch && (cnt_q != {OUT_W{1'b1}});
  assign dec = done && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (inc && !dec) cnt_q <= cnt_q + 1'b1;
    else if (dec && !inc) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R10: a byte handed over makes the tracker busy
  a_r10_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !clear) |=> busy);
  // R5: a port reset empties the tracker
  a_r5_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !busy);
endmodule

// File: rtl/spi_flash_ctl_seq.sv
module spi_flash_ctl_seq
  import sfseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCS    = 4,
  parameter int OUT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [2:0]        fmt_sel,
  input  logic              flash_mode,
  input  logic [2:0]        sample_bytes,
  output logic              tx_clr,
  output logic              rx_clr,
  output logic [NCS-1:0]    cs_lines,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [7:0]        push_data,
  input  logic              fifo_empty,
  input  logic [7:0]        fifo_rdata,
  output logic              fifo_pop,
  output logic              sh_valid,
  input  logic              sh_ready,
  output logic [7:0]        sh_data,
  input  logic              sh_done,
  output logic              underrun,
  output logic              busy
);
  logic [31:0] ctl_q;
  logic        ctl_wr, prst_now, data_wr;

  assign data_wr = wr_en && (wr_addr[1:0] == 2'b00) && (wr_addr == ADDR_W'(OFF_DATA));

  sfseq_ctl_reg #(.ADDR_W(ADDR_W), .NCS(NCS)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .flash_mode(flash_mode), .rd_data(rd_data), .ctl_q(ctl_q),
    .ctl_wr(ctl_wr), .prst_now(prst_now), .tx_clr(tx_clr), .rx_clr(rx_clr),
    .cs_lines(cs_lines)
  );

  sfseq_tx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctl_wr(ctl_wr), .prst_now(prst_now),
    .wr_data(wr_data), .ctl_q(ctl_q), .fmt_sel(fmt_sel), .sample_bytes(sample_bytes),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
    .sh_valid(sh_valid), .sh_ready(sh_ready), .sh_data(sh_data), .underrun(underrun)
  );

  sfseq_busy #(.OUT_W(OUT_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .launch(fifo_pop), .done(sh_done), .clear(prst_now),
    .busy(busy)
  );
endmodule

// File: tb/sim_spi_flash_ctl_seq.sv
module sim_spi_flash_ctl_seq;
  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [2:0]  fmt_sel = 3'd0, sample_bytes = 3'd4;
  logic        flash_mode = 1'b0;
  logic        tx_clr, rx_clr, push_valid, push_ready, fifo_empty, fifo_pop;
  logic        sh_valid, sh_ready, sh_done, underrun, busy;
  logic [3:0]  cs_lines;
  logic [7:0]  push_data, fifo_rdata, sh_data;

  always #10 clk = ~clk;

  spi_flash_ctl_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fmt_sel(fmt_sel), .flash_mode(flash_mode),
    .sample_bytes(sample_bytes), .tx_clr(tx_clr), .rx_clr(rx_clr), .cs_lines(cs_lines),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
    .sh_valid(sh_valid), .sh_ready(sh_ready), .sh_data(sh_data), .sh_done(sh_done),
    .underrun(underrun), .busy(busy)
  );

  // transmit FIFO model
  logic [7:0] fmem [DEPTH];
  int fwr = 0, frd = 0, fcnt = 0;
  assign push_ready = (fcnt < DEPTH);
  assign fifo_empty = (fcnt == 0);
  assign fifo_rdata = fmem[frd];
  always @(posedge clk) begin
    if (!rst_n || tx_clr) begin
      fwr <= 0; frd <= 0; fcnt <= 0;
    end else begin
      if (push_valid && push_ready) begin
        fmem[fwr] <= push_data;
        fwr <= (fwr + 1) % DEPTH;
      end
      if (fifo_pop) frd <= (frd + 1) % DEPTH;
      fcnt <= fcnt + ((push_valid && push_ready) ? 1 : 0) - (fifo_pop ? 1 : 0);
    end
  end

  // shifter model: done three edges after acceptance
  logic       rdy_always = 1'b1, tog = 1'b0;
  logic [2:0] dpipe = '0;
  assign sh_ready = rdy_always | tog;
  assign sh_done  = dpipe[2];
  always @(posedge clk) begin
    tog   <= ~tog;
    dpipe <= {dpipe[1:0], sh_valid && sh_ready};
  end

  int errors = 0, checks = 0, un_cnt = 0, sh_seen = 0;
  logic [7:0] exp_q [$];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (underrun) un_cnt++;
      if (sh_valid && sh_ready) begin
        sh_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected byte", {24'd0, sh_data}, 32'd0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(sh_data == e, "R8 byte order", {24'd0, sh_data}, {24'd0, e});
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // driver: data write plus expected shifter bytes
  task automatic send_word(input logic [31:0] w, input int nb, input bit drains);
    int fit;
    fit = (nb < DEPTH - fcnt) ? nb : DEPTH - fcnt;
    if (drains) for (int i = 0; i < fit; i++) exp_q.push_back(w[i*8 +: 8]);
    sample_bytes = 3'(nb);
    wr(8'h18, w);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int un0, seen0;
    bit hit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(8'h08, v);
    chk(v == 0, "R1 ctl word", v, 0);
    chk(cs_lines == 4'hF, "R1 cs", {28'd0, cs_lines}, 32'hF);
    chk(!busy && !tx_clr && !rx_clr && !push_valid && !sh_valid, "R1 outputs", {27'd0, busy, tx_clr, rx_clr, push_valid, sh_valid}, 0);
    // R2 read map
    rd(8'h60, v); chk(v == 32'h0001_1901, "R2 rev", v, 32'h0001_1901);
    rd(8'h64, v); chk(v == 32'h660F_0F1F, "R2 feat", v, 32'h660F_0F1F);
    rd(8'h09, v); chk(v == 0, "R2 misaligned", v, 0);
    rd(8'h0C, v); chk(v == 0, "R2 other", v, 0);
    // R7 push, not SPI
    wr(8'h08, 32'h1);
    send_word(32'hA1B2C3D4, 4, 0); idle(8);
    chk(fcnt == 4, "R7 count", fcnt, 4);
    chk(fmem[0] == 8'hD4 && fmem[3] == 8'hA1, "R7 lsb first", {fmem[0], fmem[3]}, 16'hD4A1);
    send_word(32'h0077_6655, 3, 0); idle(8);
    chk(fcnt == 6, "R7 full drop", fcnt, 6);
    chk(fmem[4] == 8'h55 && fmem[5] == 8'h66, "R7 partial", {fmem[4], fmem[5]}, 16'h5566);
    chk(sh_seen == 0, "R8 no drain off-format", sh_seen, 0);
    // R3 misaligned writes
    wr(8'h09, 32'h0); rd(8'h08, v);
    chk(v == 32'h1, "R3 ctl kept", v, 1);
    wr(8'h19, 32'h0); idle(6);
    chk(fcnt == 6, "R3 fifo kept", fcnt, 6);
    // R4 clears
    wr(8'h08, 32'h9);
    chk(tx_clr && !rx_clr, "R4 tx strobe", {30'd0, tx_clr, rx_clr}, 2);
    rd(8'h08, v); chk(v == 32'h1, "R4 self clear", v, 1);
    @(negedge clk);
    chk(!tx_clr, "R4 one cycle", tx_clr, 0);
    chk(fcnt == 0, "R4 fifo cleared", fcnt, 0);
    wr(8'h08, 32'h5);
    chk(rx_clr && !tx_clr, "R4 rx strobe", {30'd0, tx_clr, rx_clr}, 1);
    // R7 disabled
    wr(8'h08, 32'h0);
    send_word(32'h1234, 2, 0); idle(6);
    chk(fcnt == 0, "R7 disabled", fcnt, 0);
    // R8 drain from a control write
    wr(8'h08, 32'h1);
    send_word(32'h1234, 2, 0); idle(6);
    exp_q.push_back(8'h34); exp_q.push_back(8'h12);
    fmt_sel = 3'd1;
    un0 = un_cnt;
    wr(8'h08, 32'h101); idle(20);
    chk(fcnt == 0 && exp_q.size() == 0, "R8 ctl drain", fcnt, 0);
    chk(un_cnt == un0, "R9 no false underrun", un_cnt, un0);
    // R9 underrun
    wr(8'h08, 32'h101); idle(8);
    chk(un_cnt == un0 + 1, "R9 underrun", un_cnt, un0 + 1);
    // R10 busy around a data drain with stalls
    rdy_always = 1'b0;
    seen0 = sh_seen;
    send_word(32'hCAFE_F00D, 4, 1);
    hit = 0;
    for (int i = 0; i < 30 && !hit; i++) begin @(negedge clk); hit = busy; end
    chk(hit, "R10 busy rises", busy, 1);
    hit = 0;
    for (int i = 0; i < 60 && !hit; i++) begin @(negedge clk); hit = !busy; end
    chk(hit, "R10 busy falls", busy, 0);
    chk(sh_seen == seen0 + 4 && exp_q.size() == 0, "R8 data drain", sh_seen - seen0, 4);
    chk(un_cnt == un0 + 1, "R9 no underrun on data", un_cnt, un0 + 1);
    rdy_always = 1'b1;
    send_word(32'h77, 1, 1); idle(20);
    chk(exp_q.size() == 0 && !busy, "R8 single byte", exp_q.size(), 0);
    // R6 chip selects
    flash_mode = 1'b1;
    wr(8'h08, 32'h401); chk(cs_lines == 4'b1101, "R6 sel1 low", cs_lines, 4'b1101);
    wr(8'h08, 32'hE01); chk(cs_lines == 4'hF, "R6 level high", cs_lines, 4'hF);
    wr(8'h08, 32'hC01); chk(cs_lines == 4'b0111, "R6 sel3 low", cs_lines, 4'b0111);
    // R5 port reset in flash mode
    wr(8'h08, 32'h84D);
    chk(tx_clr && rx_clr, "R5 both strobes", {30'd0, tx_clr, rx_clr}, 3);
    rd(8'h08, v); chk(v == 32'hA01, "R5 stored word", v, 32'hA01);
    chk(cs_lines == 4'hF, "R5 cs high", cs_lines, 4'hF);
    wr(8'h08, 32'h801); chk(cs_lines == 4'b1011, "R6 sel2 low", cs_lines, 4'b1011);
    flash_mode = 1'b0; #1;
    chk(cs_lines == 4'hF, "R6 non-flash", cs_lines, 4'hF);
    // R5 port reset drops busy mid-drain
    wr(8'h08, 32'h101); idle(4);
    send_word(32'h4433_2211, 4, 1);
    hit = 0;
    for (int i = 0; i < 30 && !hit; i++) begin @(negedge clk); hit = busy; end
    chk(hit, "R10 busy before reset", busy, 1);
    wr(8'h08, 32'h41);
    exp_q.delete();
    chk(!busy, "R5 busy cleared", busy, 0);
    idle(5);
    chk(!busy && !sh_valid, "R5 stays idle", busy, 0);
    chk(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule